// File: doc/BRIEF.md
# Power-Up and Auto-Address Sequencer

This block takes a display driver from reset to ready. A power-on reset loads the panel configuration, driver-count and row-count registers with their defaults. Once the external active-low reset pin has gone high, a long start-up timer runs. Software may write the three registers while it runs, so that their values are in place when addressing starts.

When the timer expires, the block enters a fixed-length addressing phase. In that phase it emits an address clock at one quarter of the oscillator rate. The register contents are frozen, writes are dropped, and reads are refused with a one-cycle rejected flag. When the addressing phase ends, the block clears the run bit of the panel configuration and so puts the panel into shutdown. It then rests in the done phase until a reset arrives.

Pulling the pin low in any phase sends the block back to the wait phase and restarts the timer. The registers keep their values across a pin reset; only the power-on reset reloads them.

Top module: `pwrup_addr_seq`

## Requirements
- R1: While `por` is high (asynchronous), `cfg_q` equals `CFG_RESET` (default 8'h01), `devices_q` and `rows_q` equal 0, `phase` is 2'b00 and `addr_clk` is 0.
- R2: `phase` encodes 2'b00 = wait/delay, 2'b01 = addressing, 2'b10 = done, and never takes 2'b11. A low sample of `rst_n_pin` at a clock edge puts `phase` at 2'b00 and restarts the delay from zero. The registers are left as they were.
- R3: `phase` becomes 2'b01 after exactly `DELAY` consecutive clock edges at which `phase` was 2'b00 and `rst_n_pin` was high (default `DELAY` = 2097152).
- R4: The addressing phase lasts exactly 4*`ADDR_CYCLES` clock cycles, after which `phase` becomes 2'b10 and stays there.
- R5: During addressing, `addr_clk` is low for two clock cycles, then high for two cycles, and repeats. It starts low and gives exactly `ADDR_CYCLES` rising edges. Outside addressing it is held low.
- R6: Writes (`wr_en`, `addr`, `wr_data`) take effect at the next clock edge in the wait and done phases. Address 4'hD is the panel configuration, 4'hE the driver count and 4'hF the row count; other addresses are ignored. Writes during addressing are ignored, so the values held at the end of the delay are the ones in force throughout addressing.
- R7: A read (`rd_en`, `addr`) outside addressing returns, one cycle later on `rd_data`, the addressed register (0 for addresses other than 4'hD..4'hF), with `rd_rej` low.
- R8: A read during addressing returns 0 on `rd_data` and raises `rd_rej` for exactly one cycle, one cycle later, without changing any register.
- R9: On entry to the done phase, bit 0 of the panel configuration (1 = normal, 0 = shutdown) is cleared. Bits 1 (pixel inversion) and 3:2 (display plane), and all other bits, are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| por | input | 1 | Internal power-on reset, active high, asynchronous |
| rst_n_pin | input | 1 | External reset, active low, synchronous to clk |
| addr | input | 4 | Register address for write and read |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| phase | output | 2 | Sequence phase: 00 wait, 01 addressing, 10 done |
| addr_clk | output | 1 | Divided address clock |
| cfg_q | output | 8 | Panel configuration register |
| devices_q | output | 8 | Driver-count register |
| rows_q | output | 8 | Row-count register |
| rd_data | output | 8 | Registered read data |
| rd_rej | output | 1 | One-cycle pulse: read refused |

## Verification
The assertions take for granted that `rst_n_pin` is already synchronous to `clk`. They also assume `por` is released only between clock edges, so `$past` is taken only after the power-on reset has loaded the state. The bench drives every input at the falling edge and samples outputs there too, one full cycle after the edge that changed them. It raises reads and writes for single cycles only. It uses `DELAY` = 200 and `ADDR_CYCLES` = 8, so that whole start-up sequences, a reset in mid-delay and a reset from power-on all fit in one short run.

// File: rtl/pas_pkg.sv
package pas_pkg;
  localparam int DIV_RATIO = 4;

  typedef enum logic [1:0] {
    PH_WAIT = 2'b00,
    PH_ADDR = 2'b01,
    PH_DONE = 2'b10
  } phase_e;

  // oscillator cycles spent in the addressing phase
  function automatic int addr_span(input int cycles);
    return cycles * DIV_RATIO;
  endfunction

  // register access is closed only while addressing runs
  function automatic logic access_open(input phase_e p);
    return p != PH_ADDR;
  endfunction
endpackage

// File: rtl/pas_delay_timer.sv
module pas_delay_timer #(
  parameter int DELAY = 2097152
) (
  input  logic clk,
  input  logic por,
  input  logic run,
  output logic done
);
  localparam int DLY_W = (DELAY > 2) ? $clog2(DELAY) : 1;
  localparam logic [DLY_W-1:0] LAST = DLY_W'(DELAY - 1);

  logic [DLY_W-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk or posedge por) begin
    if (por)        cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (done)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pas_addr_div.sv
module pas_addr_div
  import pas_pkg::*;
#(
  parameter int ADDR_CYCLES = 256
) (
  input  logic clk,
  input  logic por,
  input  logic en,
  output logic addr_clk,
  output logic done
);
  localparam int TOTAL = addr_span(ADDR_CYCLES);
  localparam int AW    = $clog2(TOTAL);
  localparam logic [AW-1:0] LAST = AW'(TOTAL - 1);

  logic [AW-1:0] cnt;

  // bit 1 of the cycle count divides by four: low two, high two
  assign addr_clk = en && cnt[1];
  assign done     = en && (cnt == LAST);

  always_ff @(posedge clk or posedge por) begin
    if (por)        cnt <= '0;
    else if (!en)   cnt <= '0;
    else if (done)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pas_regfile.sv
module pas_regfile
  import pas_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CFG_RESET = 8'h01,
  parameter logic [DATA_W-1:0] DEV_RESET = 8'h00,
  parameter logic [DATA_W-1:0] ROW_RESET = 8'h00
) (
  input  logic              clk,
  input  logic              por,
  input  phase_e            ph,
  input  logic              force_sd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] cfg_q,
  output logic [DATA_W-1:0] devices_q,
  output logic [DATA_W-1:0] rows_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_rej
);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] A_DEV = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] A_ROW = ADDR_W'(15);

  logic              open_q;
  logic              wr_ok;
  logic [DATA_W-1:0] sel;

  assign open_q = access_open(ph);
  assign wr_ok  = wr_en && open_q;

  always_comb begin
    case (addr)
      A_CFG:   sel = cfg_q;
      A_DEV:   sel = devices_q;
      A_ROW:   sel = rows_q;
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      cfg_q     <= CFG_RESET;
      devices_q <= DEV_RESET;
      rows_q    <= ROW_RESET;
    end else if (force_sd) begin
      cfg_q[0] <= 1'b0;
    end else if (wr_ok) begin
      if (addr == A_CFG) cfg_q     <= wr_data;
      if (addr == A_DEV) devices_q <= wr_data;
      if (addr == A_ROW) rows_q    <= wr_data;
    end
  end

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      rd_data <= '0;
      rd_rej  <= 1'b0;
    end else begin
      rd_data <= (rd_en && open_q) ? sel : '0;
      rd_rej  <= rd_en && !open_q;
    end
  end
endmodule

// File: rtl/pwrup_addr_seq.sv
module pwrup_addr_seq
  import pas_pkg::*;
#(
  parameter int DELAY       = 2097152,
  parameter int ADDR_CYCLES = 256,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter logic [DATA_W-1:0] CFG_RESET = 8'h01
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst_n_pin,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [1:0]        phase,
  output logic              addr_clk,
  output logic [DATA_W-1:0] cfg_q,
  output logic [DATA_W-1:0] devices_q,
  output logic [DATA_W-1:0] rows_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_rej
);
  phase_e ph, ph_nx;
  logic   dly_run;
  logic   dly_done;
  logic   addr_en;
  logic   addr_done;
  logic   force_sd;

  assign dly_run  = (ph == PH_WAIT) && rst_n_pin;
  assign addr_en  = (ph == PH_ADDR);
  assign force_sd = addr_done && rst_n_pin;
  assign phase    = ph;

  pas_delay_timer #(.DELAY(DELAY)) u_dly (
    .clk(clk), .por(por), .run(dly_run), .done(dly_done)
  );

  pas_addr_div #(.ADDR_CYCLES(ADDR_CYCLES)) u_div (
    .clk(clk), .por(por), .en(addr_en), .addr_clk(addr_clk), .done(addr_done)
  );

  pas_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_RESET(CFG_RESET),
    .DEV_RESET('0), .ROW_RESET('0)
  ) u_rf (
    .clk(clk), .por(por), .ph(ph), .force_sd(force_sd),
    .addr(addr), .wr_data(wr_data), .wr_en(wr_en), .rd_en(rd_en),
    .cfg_q(cfg_q), .devices_q(devices_q), .rows_q(rows_q),
    .rd_data(rd_data), .rd_rej(rd_rej)
  );

  always_comb begin
    ph_nx = ph;
    if (!rst_n_pin) ph_nx = PH_WAIT;
    else begin
      case (ph)
        PH_WAIT: if (dly_done)  ph_nx = PH_ADDR;
        PH_ADDR: if (addr_done) ph_nx = PH_DONE;
        default: ph_nx = PH_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or posedge por) begin
    if (por) ph <= PH_WAIT;
    else     ph <= ph_nx;
  end
endmodule

// File: rtl/pas_checker.sv
module pas_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              por,
  input logic              rst_n_pin,
  input logic              rd_en,
  input logic [1:0]        phase,
  input logic              addr_clk,
  input logic [DATA_W-1:0] cfg_q,
  input logic [DATA_W-1:0] devices_q,
  input logic [DATA_W-1:0] rows_q,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_rej,
  input logic              dly_done,
  input logic              addr_done
);
  p_pin_wait_r2: assert property (@(posedge clk) disable iff (por)
    !rst_n_pin |=> phase == 2'b00);

  p_phase_legal_r2: assert property (@(posedge clk) disable iff (por)
    phase != 2'b11);

  p_enter_addr_r3: assert property (@(posedge clk) disable iff (por)
    dly_done |=> phase == 2'b01);

  p_addr_cause_r3: assert property (@(posedge clk) disable iff (por)
    (phase == 2'b01 && $past(phase) != 2'b01) |-> $past(dly_done));

  p_leave_addr_r4: assert property (@(posedge clk) disable iff (por)
    (phase == 2'b10 && $past(phase) == 2'b01) |-> $past(addr_done));

  p_clk_idle_r5: assert property (@(posedge clk) disable iff (por)
    phase != 2'b01 |-> !addr_clk);

  p_frozen_r6: assert property (@(posedge clk) disable iff (por)
    phase == 2'b01 |=> $stable(devices_q) && $stable(rows_q));

  p_shutdown_r9: assert property (@(posedge clk) disable iff (por)
    (phase == 2'b10 && $past(phase) == 2'b01)
      |-> !cfg_q[0] && (cfg_q[DATA_W-1:1] == $past(cfg_q[DATA_W-1:1])));

  p_reject_r8: assert property (@(posedge clk) disable iff (por)
    (rd_en && phase == 2'b01) |=> rd_rej && rd_data == '0);

  p_accept_r7: assert property (@(posedge clk) disable iff (por)
    (rd_en && phase != 2'b01) |=> !rd_rej);
endmodule

bind pwrup_addr_seq pas_checker u_chk (.*);

// File: tb/sim_pwrup_addr_seq.sv
module sim_pwrup_addr_seq;
  localparam int CLK_P = 10;
  localparam int DLY   = 200;
  localparam int NCYC  = 8;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       rst_n_pin = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] phase;
  logic       addr_clk;
  logic [7:0] cfg_q, devices_q, rows_q, rd_data;
  logic       rd_rej;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  pwrup_addr_seq #(.DELAY(DLY), .ADDR_CYCLES(NCYC)) u0 (
    .clk(clk), .por(por), .rst_n_pin(rst_n_pin), .addr(addr),
    .wr_data(wr_data), .wr_en(wr_en), .rd_en(rd_en), .phase(phase),
    .addr_clk(addr_clk), .cfg_q(cfg_q), .devices_q(devices_q),
    .rows_q(rows_q), .rd_data(rd_data), .rd_rej(rd_rej)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 19) & 255);
  endfunction

  function automatic logic [7:0] reg_exp(input int a, input logic [7:0] c,
                                         input logic [7:0] d, input logic [7:0] r);
    if (a == 13) return c;
    if (a == 14) return d;
    if (a == 15) return r;
    return 8'h00;
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    addr = 4'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [7:0] exp, input string req);
    addr = 4'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, int'(rd_data), int'(exp));
    chk(req, int'(rd_rej), 0);
  endtask

  task automatic wait_phase(input logic [1:0] p);
    while (phase != p) @(negedge clk);
  endtask

  task automatic check_reset(input string req);
    chk(req, int'(cfg_q), 8'h01);
    chk(req, int'(devices_q), 0);
    chk(req, int'(rows_q), 0);
    chk(req, int'(phase), 0);
    chk(req, int'(addr_clk), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0, n, rises, mism;
    logic prev;
    logic [7:0] dv, rw;

    repeat (3) @(negedge clk);
    check_reset("R1 power-on defaults");
    por = 1'b0;

    // pin held low far beyond the delay: stays in wait
    repeat (DLY + 100) @(negedge clk);
    chk("R2 pin low holds wait", int'(phase), 0);

    rst_n_pin = 1'b1; c0 = cyc;
    // write sweep over all addresses, then read back
    for (int a = 0; a < 16; a++) wr(a, pat(a));
    chk("R6 write cfg", int'(cfg_q), int'(pat(13)));
    chk("R6 write devices", int'(devices_q), int'(pat(14)));
    chk("R6 write rows", int'(rows_q), int'(pat(15)));
    for (int a = 0; a < 16; a++)
      rd(a, reg_exp(a, pat(13), pat(14), pat(15)), "R7 readback sweep");
    wr(13, 8'h0F);
    chk("R6 cfg rewrite", int'(cfg_q), 8'h0F);
    dv = devices_q; rw = rows_q;

    wait_phase(2'b01);
    chk("R3 delay length", cyc - c0, DLY);

    n = 0; rises = 0; mism = 0; prev = 1'b0;
    while (phase == 2'b01) begin
      n++;
      if (addr_clk && !prev) rises++;
      if (int'(addr_clk) != (((n - 1) >> 1) & 1)) mism++;
      prev = addr_clk;
      @(negedge clk);
    end
    chk("R4 addressing length", n, 4 * NCYC);
    chk("R4 done phase", int'(phase), 2);
    chk("R5 address clock rises", rises, NCYC);
    chk("R5 address clock pattern", mism, 0);
    chk("R5 clock low when done", int'(addr_clk), 0);
    chk("R9 shutdown keeps other bits", int'(cfg_q), 8'h0E);
    chk("R6 devices kept through addressing", int'(devices_q), int'(dv));
    chk("R6 rows kept through addressing", int'(rows_q), int'(rw));
    rd(13, 8'h0E, "R7 read in done");
    wr(15, 8'h33);
    chk("R6 write in done", int'(rows_q), 8'h33);
    repeat (20) @(negedge clk);
    chk("R4 done is sticky", int'(phase), 2);

    // second sequence with a pin reset in mid-delay
    rst_n_pin = 1'b0;
    @(negedge clk);
    chk("R2 pin low from done", int'(phase), 0);
    chk("R2 registers kept on pin reset", int'(rows_q), 8'h33);
    rst_n_pin = 1'b1;
    wr(13, 8'h0B);
    repeat (50) @(negedge clk);
    rst_n_pin = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 mid-delay pin reset", int'(phase), 0);
    rst_n_pin = 1'b1; c0 = cyc;
    wait_phase(2'b01);
    chk("R2 delay restarts from zero", cyc - c0, DLY);

    repeat (3) @(negedge clk);
    addr = 4'd13; rd_en = 1'b1; wr_en = 1'b1; wr_data = 8'h77;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R8 rejected flag", int'(rd_rej), 1);
    chk("R8 rejected data zero", int'(rd_data), 0);
    chk("R6 write ignored in addressing", int'(cfg_q), 8'h0B);
    @(negedge clk);
    chk("R8 flag is one cycle", int'(rd_rej), 0);
    addr = 4'd15; wr_data = 8'h55; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R6 rows write ignored in addressing", int'(rows_q), 8'h33);
    wait_phase(2'b10);
    chk("R9 shutdown on second run", int'(cfg_q), 8'h0A);
    rd(15, 8'h33, "R8 no register change");

    // power-on reset in the middle of operation
    @(negedge clk);
    por = 1'b1;
    #1;
    check_reset("R1 power-on mid-run");
    @(negedge clk);
    por = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule